// File: doc/BRIEF.md
# Status Flag Unit

This block derives the condition flags that follow an integer operation and keeps them in a 32-bit flags word. The operation is chosen by a code: add, subtract, AND, OR, XOR or pass-through. The operand width is 8, 16 or 32 bits. The block forms the result of the chosen operation from the two source operands at the selected width, computes the flags from that result, and writes them into the word on a clock edge where the update strobe is high. Each flag sits at a fixed bit position, so the rest of the datapath can test a flag by its bit index.

The same word holds two control bits, string direction and interrupt enable. Four one-hot-style commands, one per bit value, set or clear them without touching any other bit. A separate load path writes the whole word in one cycle, and the word is always visible on the output. Reserved positions are forced: bit 1 is one and every other reserved bit is zero. The flags word is a register, so its output changes one clock after the inputs that cause the change.

Top module: `status_flag_unit`

## Requirements
- R1: After synchronous reset the flags word reads 0x00000002.
- R2: The flag positions are carry 0, parity 2, aux-carry 4, zero 6, sign 7, interrupt-enable 9, direction 10, overflow 11. Bit 1 always reads one and all other positions read zero, including after a load of all ones, which reads back 0x00000ED7.
- R3: Width codes are 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. For add (op 0) the carry is the carry out of the top bit at the selected width. For subtract (op 1, A minus B) the carry is the borrow, set exactly when A is less than B as unsigned values at that width.
- R4: For add and subtract, overflow is set exactly when the signed two's-complement result falls outside the range of the selected width.
- R5: For every operation, zero is set when the result at the selected width is all zeros and sign equals the result's top bit at that width. Operand bits above the selected width have no effect.
- R6: For add, aux-carry is the carry out of bit 3. For subtract, it is set when the low nibble of A is less than the low nibble of B.
- R7: Parity is set when bits 7..0 of the result hold an even number of ones, at every width.
- R8: For AND (op 2), OR (op 3) and XOR (op 4), carry and overflow are cleared and aux-carry keeps its previous value.
- R9: Pass-through (op 5; codes 6 and 7 behave the same) takes operand A as the result. It updates zero, sign and parity, and leaves carry, overflow and aux-carry unchanged.
- R10: Command codes: 1 clears direction, 2 sets direction, 3 clears interrupt-enable, 4 sets interrupt-enable, and 0, 5, 6, 7 do nothing. A command changes only its own bit and may be combined with a flag update in the same cycle.
- R11: A load writes the load word into the flag and control positions, with reserved positions forced as in R2. A load takes priority over both a flag update and a command given in the same cycle.
- R12: With no update, no command and no load, the flags word holds its value whatever the operands and op code are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Write the computed arithmetic flags this edge |
| op_sel | input | 3 | Operation code (see R3, R8, R9) |
| width_sel | input | 2 | Operand width code (see R3) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| ctl_cmd | input | 3 | Control-bit command (see R10) |
| load_en | input | 1 | Write the whole flags word from load_word |
| load_word | input | 32 | Value for a whole-word load |
| flags | output | 32 | Registered flags word |

## Verification
The bench builds the block at its default 32-bit data width, so all three operand widths are reachable. At the byte width, add and subtract are swept over every value of A against a dense stride of B values. This covers every carry, borrow, nibble-borrow and signed-overflow boundary of the 8-bit lane. The 16- and 32-bit lanes get seeded random vectors plus the exact signed and unsigned wrap points. Junk is placed in the operand bits above the selected width, so R5 is exercised on every vector. Logic, pass-through, command, load-priority and hold cycles are mixed into a running reference state, so any bit that changes when it should not is caught on the next sample.

// File: rtl/sfu_pkg.sv
`timescale 1ns/1ps
package sfu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
    OP_XOR = 3'd4, OP_PASS = 3'd5, OP_PASS6 = 3'd6, OP_PASS7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    WD_BYTE = 2'd0, WD_HALF = 2'd1, WD_WORD = 2'd2, WD_WORD3 = 2'd3
  } width_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0, CMD_DIR_CLR = 3'd1, CMD_DIR_SET = 3'd2,
    CMD_IEN_CLR = 3'd3, CMD_IEN_SET = 3'd4, CMD_NOP5 = 3'd5,
    CMD_NOP6 = 3'd6, CMD_NOP7 = 3'd7
  } cmd_e;

  localparam int unsigned FLAGS_W = 32;
  localparam int unsigned POS_CY  = 0;
  localparam int unsigned POS_ONE = 1;
  localparam int unsigned POS_PAR = 2;
  localparam int unsigned POS_AUX = 4;
  localparam int unsigned POS_ZR  = 6;
  localparam int unsigned POS_SG  = 7;
  localparam int unsigned POS_IEN = 9;
  localparam int unsigned POS_DIR = 10;
  localparam int unsigned POS_OV  = 11;
  localparam int unsigned NUM_LANES = 3;

  localparam logic [FLAGS_W-1:0] ONE_MASK = FLAGS_W'(1) << POS_ONE;
  localparam logic [FLAGS_W-1:0] WR_MASK =
      (FLAGS_W'(1) << POS_CY)  | (FLAGS_W'(1) << POS_PAR) |
      (FLAGS_W'(1) << POS_AUX) | (FLAGS_W'(1) << POS_ZR)  |
      (FLAGS_W'(1) << POS_SG)  | (FLAGS_W'(1) << POS_IEN) |
      (FLAGS_W'(1) << POS_DIR) | (FLAGS_W'(1) << POS_OV);

  typedef struct packed {
    logic cy;
    logic ov;
    logic aux;
    logic zr;
    logic sg;
    logic par;
  } cond_t;

  function automatic logic [1:0] lane_of(width_e w);
    case (w)
      WD_BYTE: return 2'd0;
      WD_HALF: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/sfu_arith.sv
`timescale 1ns/1ps
module sfu_arith
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  op_e               op,
  input  width_e            wsel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              cy,
  output logic              ov,
  output logic              aux
);
  logic [NUM_LANES-1:0] lane_cy, lane_ov, lane_aux;
  logic [DATA_W-1:0]    lane_res  [NUM_LANES];
  logic [DATA_W-1:0]    lane_mask [NUM_LANES];
  logic                 is_sub;
  logic [1:0]           sel;
  logic [DATA_W-1:0]    logic_val;

  assign is_sub = (op == OP_SUB);
  assign sel    = lane_of(wsel);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = DATA_W >> (NUM_LANES - 1 - g);
    logic [LW-1:0] al, bl;
    logic [LW:0]   ext;
    assign al  = a[LW-1:0];
    assign bl  = b[LW-1:0];
    assign ext = is_sub ? ({1'b0, al} - {1'b0, bl}) : ({1'b0, al} + {1'b0, bl});
    assign lane_cy[g]   = ext[LW];
    assign lane_ov[g]   = (is_sub ? (al[LW-1] ^ bl[LW-1]) : ~(al[LW-1] ^ bl[LW-1]))
                          & (ext[LW-1] ^ al[LW-1]);
    assign lane_aux[g]  = al[4] ^ bl[4] ^ ext[4];
    assign lane_res[g]  = DATA_W'(ext[LW-1:0]);
    assign lane_mask[g] = DATA_W'({LW{1'b1}});
  end

  always_comb begin
    case (op)
      OP_AND:  logic_val = a & b;
      OP_OR:   logic_val = a | b;
      OP_XOR:  logic_val = a ^ b;
      default: logic_val = a;
    endcase
    if (op == OP_ADD || op == OP_SUB) res = lane_res[sel];
    else                              res = logic_val & lane_mask[sel];
    cy  = lane_cy[sel];
    ov  = lane_ov[sel];
    aux = lane_aux[sel];
  end
endmodule

// File: rtl/sfu_cond.sv
`timescale 1ns/1ps
module sfu_cond
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAR_W  = 8
) (
  input  width_e            wsel,
  input  logic [DATA_W-1:0] res,
  output logic              zr,
  output logic              sg,
  output logic              par
);
  logic [NUM_LANES-1:0] lane_zr, lane_sg;
  logic [1:0] sel;

  assign sel = lane_of(wsel);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = DATA_W >> (NUM_LANES - 1 - g);
    assign lane_zr[g] = ~|res[LW-1:0];
    assign lane_sg[g] = res[LW-1];
  end

  assign zr  = lane_zr[sel];
  assign sg  = lane_sg[sel];
  assign par = ~^res[PAR_W-1:0];
endmodule

// File: rtl/sfu_flag_reg.sv
`timescale 1ns/1ps
module sfu_flag_reg
  import sfu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  op_e                op,
  input  cond_t              cond,
  input  cmd_e               cmd,
  input  logic               ld,
  input  logic [FLAGS_W-1:0] ld_word,
  output logic [FLAGS_W-1:0] q
);
  logic [FLAGS_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (upd) begin
      nxt[POS_ZR]  = cond.zr;
      nxt[POS_SG]  = cond.sg;
      nxt[POS_PAR] = cond.par;
      case (op)
        OP_ADD, OP_SUB: begin
          nxt[POS_CY]  = cond.cy;
          nxt[POS_OV]  = cond.ov;
          nxt[POS_AUX] = cond.aux;
        end
        OP_AND, OP_OR, OP_XOR: begin
          nxt[POS_CY] = 1'b0;
          nxt[POS_OV] = 1'b0;
        end
        default: ;
      endcase
    end
    case (cmd)
      CMD_DIR_CLR: nxt[POS_DIR] = 1'b0;
      CMD_DIR_SET: nxt[POS_DIR] = 1'b1;
      CMD_IEN_CLR: nxt[POS_IEN] = 1'b0;
      CMD_IEN_SET: nxt[POS_IEN] = 1'b1;
      default: ;
    endcase
    if (ld) nxt = (ld_word & WR_MASK) | ONE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= ONE_MASK;
    else     q <= nxt;
  end

  // R2: reserved positions are fixed in every cycle after reset
  assert_rsvd_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (q & ~WR_MASK) == ONE_MASK);

  // R12: no strobe of any kind leaves the word untouched
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!upd && !ld && cmd == CMD_NONE) |=> $stable(q));

  // R10: set-direction touches only the direction bit
  assert_dir_set_R10: assert property (@(posedge clk) disable iff (rst)
    (!ld && !upd && cmd == CMD_DIR_SET) |=>
      (q[POS_DIR] && ((q & ~(FLAGS_W'(1) << POS_DIR)) == ($past(q) & ~(FLAGS_W'(1) << POS_DIR)))));

  // R8: logic ops clear carry and overflow and keep aux-carry
  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (!ld && upd && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
      (!q[POS_CY] && !q[POS_OV] && q[POS_AUX] == $past(q[POS_AUX])));

  // R5: a zero result can never carry a set sign bit
  assert_zero_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (!ld && upd) |=> !(q[POS_ZR] && q[POS_SG]));

  // R9: pass-through leaves carry, overflow and aux-carry alone
  assert_pass_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (!ld && upd && (op == OP_PASS || op == OP_PASS6 || op == OP_PASS7)) |=>
      (q[POS_CY] == $past(q[POS_CY]) && q[POS_OV] == $past(q[POS_OV]) &&
       q[POS_AUX] == $past(q[POS_AUX])));
endmodule

// File: rtl/status_flag_unit.sv
`timescale 1ns/1ps
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_en,
  input  logic [2:0]         op_sel,
  input  logic [1:0]         width_sel,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [2:0]         ctl_cmd,
  input  logic               load_en,
  input  logic [FLAGS_W-1:0] load_word,
  output logic [FLAGS_W-1:0] flags
);
  op_e               op_c;
  width_e            wd_c;
  cmd_e              cmd_c;
  logic [DATA_W-1:0] result;
  cond_t             cond;

  assign op_c  = op_e'(op_sel);
  assign wd_c  = width_e'(width_sel);
  assign cmd_c = cmd_e'(ctl_cmd);

  sfu_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op_c), .wsel(wd_c), .a(src_a), .b(src_b),
    .res(result), .cy(cond.cy), .ov(cond.ov), .aux(cond.aux)
  );

  sfu_cond #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_cond (
    .wsel(wd_c), .res(result), .zr(cond.zr), .sg(cond.sg), .par(cond.par)
  );

  sfu_flag_reg u_reg (
    .clk(clk), .rst(rst), .upd(upd_en), .op(op_c), .cond(cond),
    .cmd(cmd_c), .ld(load_en), .ld_word(load_word), .q(flags)
  );
endmodule

// File: tb/tb_status_flag_unit.sv
`timescale 1ns/1ps
module tb_status_flag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [1:0]  width_sel = 2'd0;
  logic [31:0] src_a = 32'd0, src_b = 32'd0;
  logic [2:0]  ctl_cmd = 3'd0;
  logic        load_en = 1'b0;
  logic [31:0] load_word = 32'd0;
  logic [31:0] flags;

  int vectors = 0;
  int fails = 0;
  logic [31:0] model = 32'h2;

  always #4 clk = ~clk;

  status_flag_unit dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_sel(op_sel), .width_sel(width_sel),
    .src_a(src_a), .src_b(src_b), .ctl_cmd(ctl_cmd), .load_en(load_en),
    .load_word(load_word), .flags(flags)
  );

  function automatic logic [31:0] ref_next(logic [31:0] prev, logic u, logic [2:0] op,
      logic [1:0] w, logic [31:0] a, logic [31:0] b, logic [2:0] c, logic ld,
      logic [31:0] ldd);
    int n;
    longint unsigned m, am, bm, rw;
    longint sa, sb, ss, hi, lo;
    logic [31:0] f;
    f = prev;
    if (ld) return (ldd & 32'h0000_0ED5) | 32'h2;
    n  = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    m  = (64'd1 << n) - 64'd1;
    am = {32'd0, a} & m;
    bm = {32'd0, b} & m;
    if (u) begin
      if (op == 3'd0 || op == 3'd1) begin
        sa = longint'(am) - ((am >> (n - 1)) != 0 ? longint'(64'd1 << n) : 0);
        sb = longint'(bm) - ((bm >> (n - 1)) != 0 ? longint'(64'd1 << n) : 0);
        hi = longint'((64'd1 << (n - 1)) - 64'd1);
        lo = -longint'(64'd1 << (n - 1));
        if (op == 3'd0) begin
          rw = (am + bm) & m;
          f[0] = (am + bm) > m;
          ss = sa + sb;
          f[4] = ((am & 15) + (bm & 15)) > 15;
        end else begin
          rw = (am - bm) & m;
          f[0] = am < bm;
          ss = sa - sb;
          f[4] = (am & 15) < (bm & 15);
        end
        f[11] = (ss > hi) || (ss < lo);
      end else if (op == 3'd2 || op == 3'd3 || op == 3'd4) begin
        rw = (op == 3'd2) ? (am & bm) : (op == 3'd3) ? (am | bm) : (am ^ bm);
        f[0] = 1'b0;
        f[11] = 1'b0;
      end else begin
        rw = am;
      end
      f[6] = (rw == 0);
      f[7] = rw[n-1];
      f[2] = ~^rw[7:0];
    end
    case (c)
      3'd1: f[10] = 1'b0;
      3'd2: f[10] = 1'b1;
      3'd3: f[9]  = 1'b0;
      3'd4: f[9]  = 1'b1;
      default: ;
    endcase
    return f;
  endfunction

  task automatic step(input logic u, input logic [2:0] op, input logic [1:0] w,
      input logic [31:0] a, input logic [31:0] b, input logic [2:0] c,
      input logic ld, input logic [31:0] ldd, input string tag);
    logic [31:0] exp;
    upd_en = u; op_sel = op; width_sel = w; src_a = a; src_b = b;
    ctl_cmd = c; load_en = ld; load_word = ldd;
    exp = ref_next(model, u, op, w, a, b, c, ld, ldd);
    @(negedge clk);
    vectors++;
    if (flags !== exp) begin
      fails++;
      $display("FAIL %s: op=%0d w=%0d a=%08h b=%08h cmd=%0d ld=%0b flags=%08h expected=%08h",
               tag, op, w, a, b, c, ld, flags, exp);
    end
    model = exp;
  endtask

  // operand with junk above the selected width (R5)
  function automatic logic [31:0] junk(logic [31:0] v, logic [1:0] w);
    if (w == 2'd0) return {$urandom()} & 32'hFFFF_FF00 | (v & 32'hFF);
    if (w == 2'd1) return {$urandom()} & 32'hFFFF_0000 | (v & 32'hFFFF);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: run did not finish, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    vectors++;
    if (flags !== 32'h2) begin
      fails++;
      $display("FAIL R1 reset value: flags=%08h expected=00000002", flags);
    end

    // R2 / R11: whole-word loads
    step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R2 load all ones");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, "R2 load zero");
    step(1, 3'd0, 2'd0, 32'hFF, 32'h01, 3'd2, 1, 32'h0000_0200, "R11 load beats update and cmd");
    step(1, 3'd1, 2'd2, 32'h0, 32'h1, 3'd4, 1, 32'h0000_0841, "R11 load priority");

    // R3 R4 R5 R6 R7: byte lane sweep with junk high bits
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 7) begin
        step(1, 3'd0, 2'd0, junk(a, 2'd0), junk(b, 2'd0), 3'd0, 0, 0, "R3/R4/R5/R6/R7 byte add");
        step(1, 3'd1, 2'd0, junk(a, 2'd0), junk(b, 2'd0), 3'd0, 0, 0, "R3/R4/R5/R6/R7 byte sub");
      end

    // R3 R4: wrap points at 16 and 32 bits
    step(1, 3'd0, 2'd1, 32'hABCD_7FFF, 32'h0000_0001, 3'd0, 0, 0, "R4 half signed wrap");
    step(1, 3'd0, 2'd1, 32'h0000_FFFF, 32'h5555_0001, 3'd0, 0, 0, "R3 half carry out");
    step(1, 3'd1, 2'd1, 32'h0000_8000, 32'h0000_0001, 3'd0, 0, 0, "R4 half sub overflow");
    step(1, 3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 3'd0, 0, 0, "R4 word signed wrap");
    step(1, 3'd0, 2'd3, 32'hFFFF_FFFF, 32'h0000_0001, 3'd0, 0, 0, "R3 word carry code 3");
    step(1, 3'd1, 2'd2, 32'h0000_0000, 32'h0000_0001, 3'd0, 0, 0, "R3 word borrow");
    step(1, 3'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 3'd0, 0, 0, "R4 word sub overflow");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] w;
      w = (i % 2 == 0) ? 2'd1 : 2'd2;
      step(1, 3'd0, w, junk($urandom(), w), junk($urandom(), w), 3'd0, 0, 0, "R3/R4/R5/R6/R7 wide add");
      step(1, 3'd1, w, junk($urandom(), w), junk($urandom(), w), 3'd0, 0, 0, "R3/R4/R5/R6/R7 wide sub");
    end

    // R8: logic ops after aux-carry set and after aux-carry clear
    for (int i = 0; i < 1500; i++) begin
      logic [1:0] w;
      w = 2'($urandom_range(0, 3));
      if (i % 50 == 0) step(1, 3'd0, 2'd0, 32'h0F, (i % 100 == 0) ? 32'h01 : 32'h00, 3'd0, 0, 0, "R6 aux prime");
      step(1, 3'(2 + (i % 3)), w, junk($urandom(), w), junk($urandom(), w), 3'd0, 0, 0, "R8 logic op");
    end

    // R9: pass-through codes 5..7 with carry/overflow/aux set beforehand
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0811, "R9 preload C O A");
    for (int i = 0; i < 600; i++) begin
      logic [1:0] w;
      w = 2'($urandom_range(0, 3));
      step(1, 3'(5 + (i % 3)), w, junk($urandom(), w), $urandom(), 3'd0, 0, 0, "R9 pass through");
    end
    step(1, 3'd5, 2'd0, 32'hFFFF_FF00, 0, 3'd0, 0, 0, "R5 byte zero with junk");
    step(1, 3'd5, 2'd1, 32'h0000_8003, 0, 3'd0, 0, 0, "R7 half sign and parity");

    // R10: each command from random starting words, alone and with an update
    for (int i = 0; i < 400; i++) begin
      step(0, 0, 0, 0, 0, 0, 1, $urandom(), "R10 preload");
      step(i % 2 == 1, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom(), $urandom(),
           3'(i % 8), 0, 0, "R10 command");
    end

    // R12: idle cycles with moving operands
    for (int i = 0; i < 300; i++)
      step(0, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom(), $urandom(),
           (i % 2 == 0) ? 3'd0 : 3'($urandom_range(5, 7)), 0, $urandom(), "R12 hold");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule